// File: doc/BRIEF.md
# Codec Serial Control Port

This block is the byte-wide serial control interface of a telephony codec. A host frames transfers with an active-low chip select and clocks bits in on a serial clock. The block oversamples that clock with the system clock. Each bit is sampled on a falling serial clock edge, most significant bit first. The first byte of every instruction carries a power bit, a five-bit register code and a read/write flag. A single-byte form only changes the power state. The two-byte forms either load the following byte into one of ten programmable registers or shift that register back out on a serial output that is only enabled during a chip-select window.

The block holds the register file and the power-down flag, and it gates the PCM output enable. After a power-up, that enable stays off until the second frame-sync pulse. The second byte of a two-byte instruction may follow inside the same chip-select window or in a separate one. A byte cut short by chip select rising is thrown away. An instruction that is still waiting for its second byte keeps waiting.

Top module: `codec_ctrl_port`

## Requirements
- R1: After asynchronous reset, `pwr_dn` is 1, every register in `regs_flat` is 0, `pcm_oe` is 0 and `sdo_oe` is 0.
- R2: A write instruction loads its second byte, sent in a separate chip-select window, into the selected register once the eighth bit of that byte has been sampled on a falling serial clock edge. The register value is taken MSB first.
- R3: The second byte of a write is accepted when it follows the first byte directly within one continuous chip-select low window.
- R4: After a read instruction, the next eight rising serial clock edges in a chip-select low window drive the selected register onto `sdo`, MSB first. `sdo_oe` is 1 while those bits are driven.
- R5: `sdo_oe` is 0 whenever `csn` is high.
- R6: First byte layout: bit 7 is the power bit (1 = power down, 0 = power up), bits 6..2 are the register code and bit 1 is 1 for read and 0 for write. Code 0 with bit 1 = 0 is a single-byte power instruction. Every mapped instruction, read or write, sets `pwr_dn` to its bit 7, so a register can be written in either power state.
- R7: Bit 0 of the first byte has no effect on decoding.
- R8: A first byte whose code is unmapped (code 0 with bit 1 = 1, or code 11 to 31) changes neither `pwr_dn` nor any register. The byte that follows it is discarded and not decoded as an instruction.
- R9: If `csn` rises before eight bits of a byte have been sampled, the partial bits are discarded and the next window starts a fresh byte.
- R10: A write that is waiting for its second byte keeps waiting across an aborted partial byte. The next complete byte is written to the register.
- R11: `pcm_oe` is 0 while powered down. After power-up it stays 0 until the second rising edge of `fsync`, and then becomes 1.
- R12: Register codes map as follows: 1 control, 2 latch direction, 3 latch content, 4 transmit time slot, 5 receive time slot, 6 transmit gain, 7 receive gain, 8/9/10 hybrid balance 1/2/3. Register code n sits at `regs_flat[(n-1)*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial control clock, idle low |
| csn | input | 1 | Active-low chip select framing transfers |
| sdi | input | 1 | Serial instruction/data input |
| fsync | input | 1 | PCM frame-sync pulse |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for sdo (0 = high impedance) |
| pwr_dn | output | 1 | Power-down flag (1 = powered down) |
| pcm_oe | output | 1 | PCM output driver enable |
| regs_flat | output | NREG*8 | Register file contents, code n at bits (n-1)*8 upward |

## Verification
Some properties are checked by the embedded assertions on every cycle. The serial output is never enabled while chip select is high. The power flag and the register file change only in the cycle a complete byte is delivered. Completed bytes come only from inside a chip-select window. The bit counter clears whenever the port is deselected. The PCM enable drops after a power-down and never rises while powered down. Other behaviours need the bench's directed scenarios, because they depend on byte sequences: correct register values and MSB-first readback, the single-window versus two-window second byte, discarding after an unmapped code, partial-byte recovery, the pending write that survives an abort, and counting exactly two frame syncs after power-up.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        ST_FIRST,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } ccp_state_e;
endpackage

// File: rtl/ccp_sync.sv
`timescale 1ns/1ps
module ccp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ccp_shifter.sv
`timescale 1ns/1ps
module ccp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_act,
    input  logic         bit_fall,
    input  logic         din,
    output logic         byte_vld,
    output logic [W-1:0] byte_dat
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  sh;
        logic          vld;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (!cs_act) begin
            d.cnt = '0;
        end else if (bit_fall) begin
            d.sh = {q.sh[W-2:0], din};
            if (q.cnt == CW'(W-1)) begin
                d.cnt = '0;
                d.vld = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld = q.vld;
    assign byte_dat = q.sh;

    // R9: a deselected port restarts its bit count
    a_r9_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (q.cnt == '0));
    // R2: a completed byte only comes out of a select window
    a_r2_byte_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> $past(cs_act));
endmodule

// File: rtl/ccp_pcm_gate.sv
`timescale 1ns/1ps
module ccp_pcm_gate #(
    parameter int GATE_FS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_s,
    input  logic pwr_dn,
    output logic pcm_oe
);
    localparam int CW = $clog2(GATE_FS + 1);

    typedef struct packed {
        logic          fs_p;
        logic [CW-1:0] cnt;
        logic          oe;
    } pg_t;

    pg_t d, q;

    always_comb begin
        d      = q;
        d.fs_p = fs_s;
        if (pwr_dn) begin
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (!q.oe && fs_s && !q.fs_p) begin
            if (q.cnt == CW'(GATE_FS - 1)) d.oe = 1'b1;
            else                           d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pcm_oe = q.oe;

    // R11: powered down forces the PCM enable off next cycle
    a_r11_off_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !pcm_oe);
    // R11: enable only rises out of a powered-up cycle
    a_r11_rise_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_oe) |-> !$past(pwr_dn));
endmodule

// File: rtl/codec_ctrl_port.sv
`timescale 1ns/1ps
module codec_ctrl_port
    import ccp_pkg::*;
#(
    parameter int NREG        = 10,
    parameter int SYNC_STAGES = 2,
    parameter int GATE_FS     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   csn,
    input  logic                   sdi,
    input  logic                   fsync,
    output logic                   sdo,
    output logic                   sdo_oe,
    output logic                   pwr_dn,
    output logic                   pcm_oe,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        ccp_state_e                   st;
        logic [IDX_W-1:0]             sel;
        logic                         pwr_dn;
        logic [BYTE_W-1:0]            osh;
        logic                         sdo;
        logic                         sclk_p;
        logic [NREG-1:0][BYTE_W-1:0]  regs;
    } port_t;

    localparam port_t RST_Q = '{st: ST_FIRST, sel: '0, pwr_dn: 1'b1,
                                osh: '0, sdo: 1'b0, sclk_p: 1'b0, regs: '0};

    port_t d, q;

    logic              sclk_s, csn_s, sdi_s, fs_s;
    logic              sclk_rise, sclk_fall;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_dat;
    logic [CODE_W-1:0] code;
    logic              rd_flag, mapped;

    ccp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
    ccp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst_n(rst_n), .din(csn), .dout(csn_s));
    ccp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_s));
    ccp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_fs (
        .clk(clk), .rst_n(rst_n), .din(fsync), .dout(fs_s));

    assign sclk_rise = sclk_s & ~q.sclk_p;
    assign sclk_fall = ~sclk_s & q.sclk_p;

    ccp_shifter #(.W(BYTE_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .cs_act(~csn_s), .bit_fall(sclk_fall),
        .din(sdi_s), .byte_vld(byte_vld), .byte_dat(byte_dat));

    assign code    = byte_dat[6:2];
    assign rd_flag = byte_dat[1];
    assign mapped  = (code != '0) && (code <= CODE_W'(NREG));

    always_comb begin
        d        = q;
        d.sclk_p = sclk_s;

        if (q.st == ST_READ && !csn_s && sclk_rise) begin
            d.sdo = q.osh[BYTE_W-1];
            d.osh = {q.osh[BYTE_W-2:0], 1'b0};
        end

        if (byte_vld) begin
            unique case (q.st)
                ST_FIRST: begin
                    if (code == '0 && !rd_flag) begin
                        d.pwr_dn = byte_dat[7];
                    end else if (mapped) begin
                        d.pwr_dn = byte_dat[7];
                        d.sel    = IDX_W'(code - 1'b1);
                        if (rd_flag) begin
                            d.st  = ST_READ;
                            d.osh = q.regs[IDX_W'(code - 1'b1)];
                        end else begin
                            d.st  = ST_WRITE;
                        end
                    end else begin
                        d.st = ST_SKIP;
                    end
                end
                ST_WRITE: begin
                    d.regs[q.sel] = byte_dat;
                    d.st          = ST_FIRST;
                end
                default: d.st = ST_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_Q;
        else        q <= d;
    end

    ccp_pcm_gate #(.GATE_FS(GATE_FS)) u_pcm_gate (
        .clk(clk), .rst_n(rst_n), .fs_s(fs_s), .pwr_dn(q.pwr_dn), .pcm_oe(pcm_oe));

    assign sdo       = q.sdo;
    assign sdo_oe    = ~csn & (q.st == ST_READ);
    assign pwr_dn    = q.pwr_dn;
    assign regs_flat = q.regs;

    // R5: serial output released while deselected
    a_r5_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        csn |-> !sdo_oe);
    // R6: power state moves only when a whole byte lands
    a_r6_power_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(pwr_dn));
    // R2: register file moves only when a whole byte lands
    a_r2_regs_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(regs_flat));
endmodule

// File: tb/tb_codec_ctrl_port.sv
`timescale 1ns/1ps
module tb_codec_ctrl_port;
    localparam int NREG = 10;

    logic clk = 1'b0;
    logic rst_n, sclk, csn, sdi, fsync;
    logic sdo, sdo_oe, pwr_dn, pcm_oe;
    logic [NREG*8-1:0] regs_flat;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic oe_all;

    always #10 clk = ~clk;

    codec_ctrl_port #(.NREG(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
        .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_dn(pwr_dn),
        .pcm_oe(pcm_oe), .regs_flat(regs_flat));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int code);
        return regs_flat[(code-1)*8 +: 8];
    endfunction

    task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = b[7-i];
            tick(10);
            sclk = 1'b1;
            tick(6);
            got[7-i] = sdo;
            oe_all = oe_all & sdo_oe;
            tick(4);
            sclk = 1'b0;
            tick(10);
        end
    endtask

    task automatic cs_lo();
        csn = 1'b0;
        tick(10);
    endtask

    task automatic cs_hi();
        csn = 1'b1;
        tick(10);
    endtask

    task automatic send_win(input logic [7:0] b);
        logic [7:0] g;
        cs_lo(); xfer(b, 8, g); cs_hi();
    endtask

    task automatic wr_reg(input logic [7:0] first, input logic [7:0] val);
        send_win(first);
        send_win(val);
    endtask

    task automatic rd_reg(input logic [7:0] first, output logic [7:0] val);
        send_win(first);
        cs_lo();
        oe_all = 1'b1;
        xfer(8'h00, 8, val);
        cs_hi();
    endtask

    task automatic fs_pulse();
        fsync = 1'b1;
        tick(4);
        fsync = 1'b0;
        tick(10);
    endtask

    task automatic t_reset();
        check("R1 pwr_dn", pwr_dn, 1);
        check("R1 regs", |regs_flat, 0);
        check("R1 pcm_oe", pcm_oe, 0);
        check("R1 sdo_oe", sdo_oe, 0);
    endtask

    task automatic t_two_windows();
        wr_reg(8'h84, 8'hA5);                 // code 1, P=1
        check("R2 control written", reg_at(1), 8'hA5);
        check("R12 neighbour untouched", reg_at(2), 8'h00);
    endtask

    task automatic t_same_window();
        logic [7:0] g;
        cs_lo();
        xfer(8'h88, 8, g);                    // code 2 write, P=1
        xfer(8'h3C, 8, g);
        cs_hi();
        check("R3 latch dir in one window", reg_at(2), 8'h3C);
    endtask

    task automatic t_read();
        logic [7:0] v;
        wr_reg(8'h98, 8'h96);                 // code 6 write
        send_win(8'h9A);                      // code 6 read
        check("R5 oe low between windows", sdo_oe, 0);
        cs_lo();
        oe_all = 1'b1;
        xfer(8'h00, 8, v);
        check("R4 readback value", v, 8'h96);
        check("R4 oe during readback", oe_all, 1);
        cs_hi();
        check("R5 oe low after window", sdo_oe, 0);
    endtask

    task automatic t_bit0();
        wr_reg(8'h8D, 8'h5A);                 // code 3 write, bit0 set
        check("R7 bit0 ignored", reg_at(3), 8'h5A);
    endtask

    task automatic t_power();
        send_win(8'h00);
        check("R6 single-byte power up", pwr_dn, 0);
        wr_reg(8'h90, 8'h11);                 // code 4, P=1
        check("R6 write sets power down", pwr_dn, 1);
        check("R6 write while going down", reg_at(4), 8'h11);
        wr_reg(8'h14, 8'h22);                 // code 5, P=0
        check("R6 write sets power up", pwr_dn, 0);
        check("R12 rx slot", reg_at(5), 8'h22);
        send_win(8'h80);
        check("R6 single-byte power down", pwr_dn, 1);
    endtask

    task automatic t_unmapped();
        logic [79:0] snap;
        snap = regs_flat;
        send_win(8'h7C);                      // code 31, P=0
        check("R8 unmapped keeps power", pwr_dn, 1);
        send_win(8'h00);                      // must be discarded
        check("R8 follower discarded", pwr_dn, 1);
        check("R8 regs unchanged", regs_flat == snap, 1);
        send_win(8'h00);                      // now a real instruction
        check("R8 decoding resumes", pwr_dn, 0);
    endtask

    task automatic t_partial();
        logic [7:0] g;
        cs_lo(); xfer(8'h80, 3, g); cs_hi();
        check("R9 partial no effect", pwr_dn, 0);
        cs_lo();
        xfer(8'h04, 8, g);                    // code 1 write, P=0
        xfer(8'h77, 8, g);
        cs_hi();
        check("R9 fresh byte aligned", reg_at(1), 8'h77);
        check("R9 power stays up", pwr_dn, 0);
    endtask

    task automatic t_pending();
        logic [7:0] g;
        send_win(8'h10);                      // code 4 write, P=0
        cs_lo(); xfer(8'hFF, 5, g); cs_hi();
        check("R10 not yet written", reg_at(4), 8'h11);
        send_win(8'h3D);
        check("R10 pending write completes", reg_at(4), 8'h3D);
    endtask

    task automatic t_pcm();
        send_win(8'h80);
        fs_pulse(); fs_pulse();
        check("R11 off while down", pcm_oe, 0);
        send_win(8'h00);
        check("R11 off right after power up", pcm_oe, 0);
        fs_pulse();
        check("R11 off after first fs", pcm_oe, 0);
        fs_pulse();
        check("R11 on after second fs", pcm_oe, 1);
        send_win(8'h80);
        tick(3);
        check("R11 off after power down", pcm_oe, 0);
    endtask

    task automatic t_hybrid();
        logic [7:0] v;
        wr_reg(8'hA0, 8'h81);
        wr_reg(8'hA4, 8'h42);
        wr_reg(8'hA8, 8'h24);
        check("R12 hybrid1 slice", reg_at(8), 8'h81);
        check("R12 hybrid3 slice", reg_at(10), 8'h24);
        rd_reg(8'hA6, v);
        check("R12 hybrid2 readback", v, 8'h42);
        rd_reg(8'hAA, v);
        check("R12 hybrid3 readback", v, 8'h24);
        rd_reg(8'hA2, v);
        check("R4 hybrid1 readback", v, 8'h81);
    endtask

    initial begin
        rst_n = 1'b0; csn = 1'b1; sclk = 1'b0; sdi = 1'b0; fsync = 1'b0;
        oe_all = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_two_windows();
        t_same_window();
        t_read();
        t_bit0();
        t_power();
        t_unmapped();
        t_partial();
        t_pending();
        t_pcm();
        t_hybrid();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule